// File: doc/BRIEF.md
# Clock consumer source mux divider

This block feeds six fixed clock consumers. Each consumer has a small selector. The selector picks one of seven candidate inputs: the auxiliary PLL clock or one of six frequency-generator outputs. It then divides that input by a small fixed ratio and drives a gated output clock and a once-per-period tick for the consumer. The candidate inputs are not real clocks. They arrive as seven single-cycle clock enables on one fast clock, so every output is a registered level in that same clock domain.

All six selectors are configured through one 32-bit source-control word, which is written and read through a synchronous register port. Each selector field has a 3-bit source code and a 2-bit divide code. A source code of zero switches the consumer off. To turn it back on, software writes back the nonzero source code it used before. A new configuration is never applied in the middle of an output period. It waits until the output is low and no division is partly done, so the output never shows a short pulse. One build option turns divide code 2 into a divide-by-3.

Top module: `clk_consumer_mux`

## Requirements
- R1: After reset the control word reads 0, every consumer output clock is low, and no tick is produced even while all inputs pulse.
- R2: Selector k occupies bits 5k+4..5k of the control word, with the divide code in bits 5k+1..5k and the source code in bits 5k+4..5k+2. Bits 31:30 always read as zero.
- R3: Source code 1 selects enable input bit 0 (the auxiliary PLL). Source codes 2 to 7 select enable input bits 1 to 6 (frequency generators 0 to 5).
- R4: Divide codes 0, 1, 2 and 3 give ratios 1, 4, 1 and 2. The output clock toggles once every ratio-many selected input pulses, so one output period spans 2 x ratio pulses. The tick is high for exactly one cycle, in the cycle in which the output clock rises.
- R5: With the divide-by-3 option enabled, divide code 2 gives ratio 3. All other codes are unchanged.
- R6: Source code 0 disables the consumer: its output clock settles low and no tick is produced.
- R7: Writing back a previously used nonzero source code re-enables the consumer, and it runs at the same period as before.
- R8: A new source or divide code takes effect only when the output is low and no division is in progress. The high phase that is under way when the write arrives keeps its old length.
- R9: While the selected input does not pulse, the output clock holds its level and the tick stays low.
- R10: A read request returns the control word on the read data port one cycle later. The read data holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, on which all inputs are sampled |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 7 | Clock enables: bit 0 auxiliary PLL, bits 1..6 generators 0..5 |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Write data |
| cfg_re | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Read data, registered |
| cons_clk | output | 6 | Gated and divided output clock per consumer |
| cons_tick | output | 6 | One-cycle pulse per output period, in the cycle the output rises |

## Verification
Read data is due one cycle after the read strobe, and the bench samples it on the falling edge after that rising edge. A new configuration shows up only at the next output boundary, which is up to one full old period later. For this reason the bench never measures the period straight after a write: it skips one tick and then times the next tick-to-tick interval, which is exactly 2 x ratio x input spacing because the input pulses come from a free-running counter. The check on R8 starts counting at the very falling edge where the rising tick is seen, so the high-phase length is exact.

// File: rtl/clk_consumer_pkg.sv
package clk_consumer_pkg;
   parameter int unsigned CC_SRC_W   = 3;
   parameter int unsigned CC_DIV_W   = 2;
   localparam int unsigned CC_FIELD_W = CC_SRC_W + CC_DIV_W;
   localparam int unsigned CC_RATIO_W = 3;

   // divide code to ratio; code 2 is 1 or 3 depending on the variant
   function automatic logic [CC_RATIO_W-1:0] cc_ratio(input logic [CC_DIV_W-1:0] code,
                                                      input bit ext_div3);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd4;
         2'd2:    return ext_div3 ? 3'd3 : 3'd1;
         default: return 3'd2;
      endcase
   endfunction
endpackage

// File: rtl/clk_consumer_cfg.sv
module clk_consumer_cfg #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned USED_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_en,
   output logic [REG_W-1:0]  rd_data,
   output logic [USED_W-1:0] cfg_q
);
   if (USED_W > REG_W) begin : g_chk_used
      $error("USED_W must not exceed REG_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         rd_data <= '0;
      end else begin
         if (wr_en) cfg_q   <= wr_data[USED_W-1:0];
         if (rd_en) rd_data <= REG_W'(cfg_q);
      end
   end

   // R2: reserved upper bits never read back as one
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data >> USED_W) == '0);
   // R10: read data reflects the word one cycle after a read strobe
   a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_data[USED_W-1:0] == $past(cfg_q));
endmodule

// File: rtl/clk_consumer_lane.sv
module clk_consumer_lane
   import clk_consumer_pkg::*;
#(
   parameter int unsigned N_SRC    = 7,
   parameter bit          EXT_DIV3 = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_SRC-1:0]    src_en,
   input  logic [CC_SRC_W-1:0] req_src,
   input  logic [CC_DIV_W-1:0] req_div,
   output logic                out_clk,
   output logic                out_tick
);
   localparam int unsigned CNT_W = CC_RATIO_W - 1;

   logic [CC_SRC_W-1:0]   act_src;
   logic [CC_DIV_W-1:0]   act_div;
   logic [CNT_W-1:0]      cnt;
   logic                  clk_q, tick_q;
   logic                  sel_en, last, boundary, commit;
   logic [CC_RATIO_W-1:0] ratio;

   // source code 0 is off; code i+1 picks enable bit i
   always_comb begin
      sel_en = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (act_src == CC_SRC_W'(i + 1)) sel_en = src_en[i];
      end
   end

   assign ratio    = cc_ratio(act_div, EXT_DIV3);
   assign last     = ({1'b0, cnt} == ratio - 3'd1);
   assign boundary = (cnt == '0) && !clk_q;
   assign commit   = boundary && ({req_src, req_div} != {act_src, act_div});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_src <= '0;
         act_div <= '0;
         cnt     <= '0;
         clk_q   <= 1'b0;
         tick_q  <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (commit) begin
            act_src <= req_src;
            act_div <= req_div;
         end else if (sel_en) begin
            if (last) begin
               cnt    <= '0;
               clk_q  <= ~clk_q;
               tick_q <= ~clk_q;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   assign out_clk  = clk_q;
   assign out_tick = tick_q;

   // R8: configuration only moves while the output was low and idle
   a_r8_commit_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({act_src, act_div}) |-> (!$past(clk_q) && $past(cnt) == '0));
   // R6: a disabled consumer is low and silent
   a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (act_src == '0) |-> (!clk_q && !tick_q));
   // R9: no input pulse, no output movement
   a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_en |=> ($stable(clk_q) && !tick_q));
   // R4: tick only on the rising output edge
   a_r4_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> (clk_q && !$past(clk_q)));
   // R4: divide counter stays below the ratio
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cnt} < ratio);
endmodule

// File: rtl/clk_consumer_mux.sv
module clk_consumer_mux
   import clk_consumer_pkg::*;
#(
   parameter int unsigned N_CONS   = 6,
   parameter int unsigned N_SRC    = 7,
   parameter int unsigned REG_W    = 32,
   parameter bit          EXT_DIV3 = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_en,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              cfg_re,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic [N_CONS-1:0] cons_clk,
   output logic [N_CONS-1:0] cons_tick
);
   localparam int unsigned USED_W = N_CONS * CC_FIELD_W;

   if (USED_W > REG_W) begin : g_chk_fit
      $error("selector fields do not fit the control word");
   end
   if (N_SRC > (1 << CC_SRC_W) - 1) begin : g_chk_src
      $error("too many sources for the source code width");
   end

   logic [USED_W-1:0] cfg_q;

   clk_consumer_cfg #(.REG_W(REG_W), .USED_W(USED_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .rd_en   (cfg_re),
      .rd_data (cfg_rdata),
      .cfg_q   (cfg_q)
   );

   for (genvar k = 0; k < N_CONS; k++) begin : g_lane
      clk_consumer_lane #(.N_SRC(N_SRC), .EXT_DIV3(EXT_DIV3)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_en   (src_en),
         .req_src  (cfg_q[k*CC_FIELD_W + CC_DIV_W +: CC_SRC_W]),
         .req_div  (cfg_q[k*CC_FIELD_W +: CC_DIV_W]),
         .out_clk  (cons_clk[k]),
         .out_tick (cons_tick[k])
      );
   end
endmodule

// File: tb/clk_consumer_mux_tb.sv
module clk_consumer_mux_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  src_en;
   logic [6:0]  src_mask = '1;
   logic        cfg_we = 1'b0, cfg_re = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] rdata, rdata_x3;
   logic [5:0]  cons_clk, cons_tick, cons_clk_x3, cons_tick_x3;
   int          cyc = 0;
   int          n_run = 0, n_fail = 0;
   logic [31:0] shadow = '0;

   always #5 clk = ~clk;

   // input j pulses once every j+1 cycles
   always @(negedge clk) cyc++;
   always_comb begin
      for (int j = 0; j < 7; j++) src_en[j] = src_mask[j] && ((cyc % (j + 1)) == 0);
   end

   clk_consumer_mux u_dut (
      .clk(clk), .rst_n(rst_n), .src_en(src_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_re(cfg_re), .cfg_rdata(rdata), .cons_clk(cons_clk), .cons_tick(cons_tick));

   clk_consumer_mux #(.EXT_DIV3(1'b1)) u_dut_x3 (
      .clk(clk), .rst_n(rst_n), .src_en(src_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_re(cfg_re), .cfg_rdata(rdata_x3), .cons_clk(cons_clk_x3), .cons_tick(cons_tick_x3));

   // {consumer, source code, divide code, expected period in cycles}
   localparam logic [19:0] VEC [8] = '{
      20'h0_1_0_02, 20'h1_1_1_08, 20'h2_2_2_04, 20'h3_3_3_0C,
      20'h4_7_1_38, 20'h5_5_0_0A, 20'h0_4_3_10, 20'h5_6_2_0C };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] put(input logic [31:0] w, input int k, input int s, input int d);
      logic [31:0] r;
      r = w;
      r[k*5 +: 2]   = 2'(d);
      r[k*5+2 +: 3] = 3'(s);
      return r;
   endfunction

   task automatic wr(input logic [31:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(output logic [31:0] v);
      cfg_re = 1'b1;
      @(negedge clk);
      cfg_re = 1'b0;
      v = rdata;
   endtask

   // time tick-to-tick on lane k of a chosen instance, after skipping one tick
   task automatic period(input int k, input bit x3, output int p);
      int t;
      p = -1;
      for (int n = 0; n < 2; n++) begin
         t = 0;
         do begin @(negedge clk); t++; end
         while (!(x3 ? cons_tick_x3[k] : cons_tick[k]) && t < 1000);
      end
      p = 0;
      do begin @(negedge clk); p++; end
      while (!(x3 ? cons_tick_x3[k] : cons_tick[k]) && p < 1000);
   endtask

   task automatic ticks(input int k, input int n, output int t, output bit rose);
      logic c0;
      t = 0; c0 = cons_clk[k]; rose = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (cons_tick[k]) t++;
         if (cons_clk[k] != c0) rose = 1'b1;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int p, t, n;
      bit mv;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(cons_clk == '0, "R1 clocks low", cons_clk, 0);
      ticks(0, 20, t, mv);
      chk(t == 0 && cons_tick == '0, "R1 no ticks", t, 0);
      rd(v);
      chk(v == 32'h0, "R1 R10 word reads zero", v, 0);

      // R2: reserved bits read zero
      wr(32'hFFFF_FFFF);
      rd(v);
      chk(v == 32'h3FFF_FFFF, "R2 reserved bits", v, 32'h3FFF_FFFF);
      wr(32'h0);
      repeat (60) @(negedge clk);

      // R3, R4: table of selections and ratios
      foreach (VEC[i]) begin
         shadow = put(shadow, int'(VEC[i][19:16]), int'(VEC[i][15:12]), int'(VEC[i][11:8]));
         wr(shadow);
         period(int'(VEC[i][19:16]), 1'b0, p);
         chk(p == int'(VEC[i][7:0]), $sformatf("R3,R4 vector %0d", i), p, int'(VEC[i][7:0]));
      end
      rd(v);
      chk(v == shadow, "R2 R10 field layout readback", v, shadow);

      // R5: variant gives divide-by-3 on code 2
      period(2, 1'b1, p);
      chk(p == 12, "R5 lane2 ratio 3", p, 12);
      period(5, 1'b1, p);
      chk(p == 36, "R5 lane5 ratio 3", p, 36);
      period(3, 1'b1, p);
      chk(p == 12, "R5 code 3 unchanged", p, 12);

      // R9: stalled source holds level
      n = 0;
      while (!cons_clk[1] && n < 100) begin @(negedge clk); n++; end
      src_mask[0] = 1'b0;
      ticks(1, 40, t, mv);
      chk(cons_clk[1] == 1'b1 && !mv, "R9 level held", cons_clk[1], 1);
      chk(t == 0, "R9 no tick", t, 0);
      src_mask[0] = 1'b1;
      period(1, 1'b0, p);
      chk(p == 8, "R9 resumes", p, 8);

      // R6: disable lane3
      shadow = put(shadow, 3, 0, 3);
      wr(shadow);
      repeat (40) @(negedge clk);
      chk(cons_clk[3] == 1'b0, "R6 output low", cons_clk[3], 0);
      ticks(3, 40, t, mv);
      chk(t == 0 && !mv, "R6 silent", t, 0);
      rd(v);
      chk(v[19:15] == 5'b000_11, "R6 source field cleared", v[19:15], 3);

      // R7: write back previous source
      shadow = put(shadow, 3, 3, 3);
      wr(shadow);
      period(3, 1'b0, p);
      chk(p == 12, "R7 re-enabled period", p, 12);

      // R8: change during the high phase waits for the boundary
      n = 0;
      do begin @(negedge clk); n++; end while (!cons_tick[4] && n < 1000);
      shadow = put(shadow, 4, 7, 0);
      cfg_we = 1'b1; cfg_wdata = shadow;
      n = 0;
      do begin @(negedge clk); cfg_we = 1'b0; n++; end while (cons_clk[4] && n < 1000);
      chk(n == 28, "R8 old high phase kept", n, 28);
      period(4, 1'b0, p);
      chk(p == 14, "R8 new ratio applied", p, 14);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule